// File: doc/BRIEF.md
# Ternary Operand-Decomposition Multiplier

This block multiplies two unsigned ternary numbers of `NT` trits each, every digit taking the value 0, 1 or 2. Each trit travels on two wires. Instead of multiplying the operands directly, the block first splits them trit by trit into four auxiliary ternary operands. It uses three gate functions for this: ternary maximum, ternary minimum and ternary complement (two minus the digit). It then forms two sub-products from those four operands and adds them with a trit-serial ripple adder. The sum is the exact product of the inputs, given as a `2*NT`-trit result.

Operands `A` and `B` split at each digit position into four digits. The first is `hi = max(a, b)`. The second is `lo = min(a, b)`. The third is `pa = min(a, 2-b)` and the fourth is `pb = min(2-a, b)`. When both inputs of a minimum that forms `pa` or `pb` equal 1, its output is forced to 0. With that override, `a = lo + pa` and `b = lo + pb` hold at every digit, and so does `hi = lo + pa + pb`. This gives `A*B = HI*LO + PA*PB`. Each sub-product is formed exactly: its operands are converted to binary, multiplied, and converted back to trits. The two trit vectors are then summed in the ternary domain.

The block is a two-stage pipeline with a valid strobe. An operand pair is accepted in every cycle in which `in_valid` is high. Its result appears two cycles later with `out_valid`. A digit code that is not a legal trit raises an error flag that travels with the result.

Top module: `tern_od_mult`

## Requirements
- R1: Every trit is encoded in two bits, least significant trit at bits [1:0]: 2'b00 is 0, 2'b01 is 1, 2'b10 is 2, and 2'b11 is illegal.
- R2: `out_valid` is `in_valid` delayed by exactly two clock cycles, and each accepted pair produces exactly one result in order.
- R3: For legal inputs, `prod_trits` decodes to the exact integer product of `a_trits` and `b_trits`, with `out_err` low.
- R4: Every trit of `prod_trits` presented with `out_valid` is a legal code (never 2'b11).
- R5: If any trit of either accepted operand is 2'b11, the matching result has `out_err` high and `prod_trits` all zero. The next legal pair is unaffected.
- R6: In a cycle with `out_valid` low, `prod_trits` and `out_err` keep the value they had in the cycle before.
- R7: While `rst_n` is low, `out_valid` and `out_err` are low and `prod_trits` is all zero.
- R8: Operands whose digits are all 1 give the exact square, which exercises the forced-zero rule on the minimum for the complement operands.
- R9: The largest operands, all digits 2, give (3^NT - 1)^2 with no lost carry out of the top result trit.
- R10: Pairs applied on consecutive cycles each produce their own correct result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| a_trits | input | 2*NT | Multiplicand, NT two-bit trits |
| b_trits | input | 2*NT | Multiplier, NT two-bit trits |
| out_valid | output | 1 | Result present this cycle |
| out_err | output | 1 | Result belongs to a pair with an illegal trit code |
| prod_trits | output | 4*NT | Product, 2*NT two-bit trits |

## Verification
The bench runs with three trits per operand and tries all 729 operand pairs back to back. This catches a decomposition that forgets the forced-zero rule on the 1-and-1 digit pairs: such a design returns a product that is too large whenever both operands hold a 1 in the same position. All-ones and all-twos operands are driven on purpose. The all-twos case catches a ternary adder that drops or misplaces a carry, which would give a wrong top trit or a result that wraps. Operands with an illegal code are followed immediately by a legal pair, and idle gaps separate the bursts. These cases show whether the error flag leaks into the next result, whether garbage from the illegal digit reaches the product, and whether the outputs move while no result is flagged.

// File: rtl/tern_od_pkg.sv
package tern_od_pkg;

    typedef logic [1:0] trit_t;

    localparam trit_t TRIT_ZERO = 2'b00;
    localparam trit_t TRIT_ONE  = 2'b01;
    localparam trit_t TRIT_TWO  = 2'b10;
    localparam trit_t TRIT_BAD  = 2'b11;

    // Number of distinct values in n trits.
    function automatic int pow3(input int n);
        int r;
        r = 1;
        for (int i = 0; i < n; i++) begin
            r = r * 3;
        end
        return r;
    endfunction

    function automatic trit_t trit_max(input trit_t x, input trit_t y);
        return (x > y) ? x : y;
    endfunction

    function automatic trit_t trit_min(input trit_t x, input trit_t y);
        return (x < y) ? x : y;
    endfunction

    function automatic trit_t trit_inv(input trit_t x);
        return TRIT_TWO - x;
    endfunction

    // Minimum used for the complement operands: 1 with 1 gives 0.
    function automatic trit_t trit_min_split(input trit_t x, input trit_t y);
        trit_t r;
        if (x == TRIT_ONE && y == TRIT_ONE) begin
            r = TRIT_ZERO;
        end else begin
            r = trit_min(x, y);
        end
        return r;
    endfunction

endpackage

// File: rtl/tern_od_split.sv
module tern_od_split
    import tern_od_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic [2*NT-1:0] a_t,
    input  logic [2*NT-1:0] b_t,
    output logic [2*NT-1:0] hi_t,
    output logic [2*NT-1:0] lo_t,
    output logic [2*NT-1:0] pa_t,
    output logic [2*NT-1:0] pb_t,
    output logic            bad
);

    logic [NT-1:0] bad_v;

    for (genvar i = 0; i < NT; i++) begin : g_digit
        trit_t ai;
        trit_t bi;
        assign ai = a_t[2*i +: 2];
        assign bi = b_t[2*i +: 2];

        assign hi_t[2*i +: 2] = trit_max(ai, bi);
        assign lo_t[2*i +: 2] = trit_min(ai, bi);
        assign pa_t[2*i +: 2] = trit_min_split(ai, trit_inv(bi));
        assign pb_t[2*i +: 2] = trit_min_split(trit_inv(ai), bi);

        assign bad_v[i] = (ai == TRIT_BAD) || (bi == TRIT_BAD);
    end

    assign bad = |bad_v;

endmodule

// File: rtl/tern_od_subprod.sv
module tern_od_subprod #(
    parameter int NT = 4,
    parameter int BW = 7
) (
    input  logic [2*NT-1:0] x_t,
    input  logic [2*NT-1:0] y_t,
    output logic [4*NT-1:0] z_t
);

    localparam int PW = 2 * BW;
    localparam int RT = 2 * NT;

    logic [BW-1:0] xb;
    logic [BW-1:0] yb;
    logic [PW-1:0] pb;
    logic [PW-1:0] rest;

    // Trits to binary, most significant digit first.
    always_comb begin
        xb = '0;
        yb = '0;
        for (int i = NT - 1; i >= 0; i--) begin
            xb = BW'(xb * BW'(3)) + BW'(x_t[2*i +: 2]);
            yb = BW'(yb * BW'(3)) + BW'(y_t[2*i +: 2]);
        end
    end

    assign pb = PW'(xb) * PW'(yb);

    // Binary back to trits, least significant digit first.
    always_comb begin
        z_t  = '0;
        rest = pb;
        for (int i = 0; i < RT; i++) begin
            z_t[2*i +: 2] = 2'(rest % PW'(3));
            rest          = rest / PW'(3);
        end
    end

endmodule

// File: rtl/tern_od_add.sv
module tern_od_add #(
    parameter int NTR = 8
) (
    input  logic [2*NTR-1:0] x_t,
    input  logic [2*NTR-1:0] y_t,
    output logic [2*NTR-1:0] s_t
);

    logic [NTR-1:0] cin;

    assign cin[0] = 1'b0;

    for (genvar i = 0; i < NTR; i++) begin : g_stage
        logic [2:0] raw;
        assign raw = {1'b0, x_t[2*i +: 2]} + {1'b0, y_t[2*i +: 2]} + {2'b00, cin[i]};
        assign s_t[2*i +: 2] = (raw >= 3'd3) ? 2'(raw - 3'd3) : raw[1:0];
        if (i < NTR - 1) begin : g_carry
            assign cin[i+1] = (raw >= 3'd3);
        end
    end

endmodule

// File: rtl/tern_od_mult.sv
module tern_od_mult
    import tern_od_pkg::*;
#(
    parameter int NT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2*NT-1:0] a_trits,
    input  logic [2*NT-1:0] b_trits,
    output logic            out_valid,
    output logic            out_err,
    output logic [4*NT-1:0] prod_trits
);

    localparam int OW = 2 * NT;
    localparam int RT = 2 * NT;
    localparam int RW = 2 * RT;
    localparam int BW = $clog2(pow3(NT));

    logic [OW-1:0] hi_c, lo_c, pa_c, pb_c;
    logic          bad_c;

    logic          s1_valid;
    logic          s1_err;
    logic [OW-1:0] s1_hi, s1_lo, s1_pa, s1_pb;

    logic [RW-1:0] sub_main;
    logic [RW-1:0] sub_cross;
    logic [RW-1:0] sum_t;

    tern_od_split #(.NT(NT)) u_split (
        .a_t  (a_trits),
        .b_t  (b_trits),
        .hi_t (hi_c),
        .lo_t (lo_c),
        .pa_t (pa_c),
        .pb_t (pb_c),
        .bad  (bad_c)
    );

    // Stage 1: split operands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_err   <= 1'b0;
            s1_hi    <= '0;
            s1_lo    <= '0;
            s1_pa    <= '0;
            s1_pb    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_err <= bad_c;
                s1_hi  <= hi_c;
                s1_lo  <= lo_c;
                s1_pa  <= pa_c;
                s1_pb  <= pb_c;
            end
        end
    end

    tern_od_subprod #(.NT(NT), .BW(BW)) u_sub_main (
        .x_t (s1_hi),
        .y_t (s1_lo),
        .z_t (sub_main)
    );

    tern_od_subprod #(.NT(NT), .BW(BW)) u_sub_cross (
        .x_t (s1_pa),
        .y_t (s1_pb),
        .z_t (sub_cross)
    );

    tern_od_add #(.NTR(RT)) u_add (
        .x_t (sub_main),
        .y_t (sub_cross),
        .s_t (sum_t)
    );

    // Stage 2: ternary sum.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_err    <= 1'b0;
            prod_trits <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_err    <= s1_err;
                prod_trits <= s1_err ? '0 : sum_t;
            end
        end
    end

endmodule

// File: rtl/tern_od_mult_chk.sv
module tern_od_mult_chk #(
    parameter int NT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2*NT-1:0] a_trits,
    input logic [2*NT-1:0] b_trits,
    input logic            out_valid,
    input logic            out_err,
    input logic [4*NT-1:0] prod_trits
);

    logic [1:0] age;
    logic       in_bad;
    logic       out_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    always_comb begin
        in_bad = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (a_trits[2*i +: 2] == 2'b11 || b_trits[2*i +: 2] == 2'b11) begin
                in_bad = 1'b1;
            end
        end
    end

    always_comb begin
        out_bad = 1'b0;
        for (int i = 0; i < 2*NT; i++) begin
            if (prod_trits[2*i +: 2] == 2'b11) begin
                out_bad = 1'b1;
            end
        end
    end

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r4_legal_trits: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_bad);

    a_r5_err_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd2) && out_valid) |-> (out_err == $past(in_bad, 2)));

    a_r5_err_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (prod_trits == '0));

    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((age >= 2'd1) && !out_valid) |-> ($stable(prod_trits) && $stable(out_err)));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r7_reset_clear: assert (!out_valid && !out_err && prod_trits == '0);
        end
    end

endmodule

bind tern_od_mult tern_od_mult_chk #(.NT(NT)) u_chk (.*);

// File: tb/tern_od_mult_test.sv
`timescale 1ns/1ps
module tern_od_mult_test;

    localparam int NT   = 3;
    localparam int MAXV = 27;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [2*NT-1:0] a_trits;
    logic [2*NT-1:0] b_trits;
    logic            out_valid;
    logic            out_err;
    logic [4*NT-1:0] prod_trits;

    typedef struct {
        int    prod;
        bit    err;
        int    stamp;
        string tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   cyc    = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   seen   = 1'b0;
    logic [4*NT-1:0] last_p;
    logic            last_e;

    tern_od_mult #(.NT(NT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .a_trits    (a_trits),
        .b_trits    (b_trits),
        .out_valid  (out_valid),
        .out_err    (out_err),
        .prod_trits (prod_trits)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // R1 encoding: 00=0, 01=1, 10=2, least significant trit lowest.
    function automatic logic [2*NT-1:0] enc(input int v);
        logic [2*NT-1:0] r;
        r = '0;
        for (int i = 0; i < NT; i++) begin
            r[2*i +: 2] = 2'(v % 3);
            v = v / 3;
        end
        return r;
    endfunction

    function automatic int dec(input logic [4*NT-1:0] p);
        int acc;
        acc = 0;
        for (int i = 2*NT - 1; i >= 0; i--) begin
            if (p[2*i +: 2] == 2'b11) return -1;
            acc = acc * 3 + int'(p[2*i +: 2]);
        end
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [2*NT-1:0] a, input logic [2*NT-1:0] b,
                        input int ep, input bit ee, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        a_trits  = a;
        b_trits  = b;
        e.prod   = ep;
        e.err    = ee;
        e.stamp  = cyc;
        e.tag    = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected items as results appear.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2", "result with nothing pending", 1, 0);
                end else begin
                    cur = q.pop_front();
                    chk(dec(prod_trits) != -1, "R4", "illegal result trit", dec(prod_trits), 0);
                    chk(out_err == cur.err, "R5", "error flag", int'(out_err), int'(cur.err));
                    chk(dec(prod_trits) == cur.prod, cur.tag, "product", dec(prod_trits), cur.prod);
                    chk(cyc == cur.stamp + 2, "R2", "latency", cyc - cur.stamp, 2);
                end
                last_p = prod_trits;
                last_e = out_err;
                seen   = 1'b1;
            end else if (seen) begin
                chk(prod_trits == last_p && out_err == last_e, "R6", "hold while idle",
                    dec(prod_trits), dec(last_p));
            end
        end
    end

    initial begin
        logic [2*NT-1:0] bad_a;
        logic [2*NT-1:0] bad_b;
        rst_n    = 1'b1;
        in_valid = 1'b0;
        a_trits  = '0;
        b_trits  = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(out_valid == 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        chk(out_err == 1'b0, "R7", "out_err in reset", int'(out_err), 0);
        chk(prod_trits == '0, "R7", "product in reset", dec(prod_trits), 0);
        rst_n = 1'b1;
        idle(2);

        send(enc(2), enc(2), 4, 1'b0, "R1");
        send(enc(13), enc(13), 169, 1'b0, "R8");
        send(enc(MAXV - 1), enc(MAXV - 1), (MAXV - 1) * (MAXV - 1), 1'b0, "R9");
        idle(3);

        bad_a = enc(5);
        bad_a[3:2] = 2'b11;
        send(bad_a, enc(7), 0, 1'b1, "R5");
        send(enc(4), enc(5), 20, 1'b0, "R5");
        bad_b = enc(8);
        bad_b[2*NT-1 -: 2] = 2'b11;
        send(enc(9), bad_b, 0, 1'b1, "R5");
        idle(3);

        // R3 and R10: every pair, one per cycle.
        for (int a = 0; a < MAXV; a++) begin
            for (int b = 0; b < MAXV; b++) begin
                send(enc(a), enc(b), a * b, 1'b0, (a == b) ? "R10" : "R3");
            end
        end
        idle(1);
        while (q.size() != 0) @(negedge clk);
        idle(3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: pending %0d expected 0", q.size());
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule